// File: doc/BRIEF.md
# Wavetable Sample Memory DMA Engine

This block moves a block of bytes between a system-side byte stream and a local byte-wide sample memory. Software programs a 16-bit paragraph start register, a 4-bit sub-paragraph register and a unit count, and then writes the control register with its request bit set. The engine forms the local address, moves one byte per accepted stream handshake, and at the end of the block advances the start registers and handles the terminal count. During this terminal-count handling it clears the request bit and can raise an interrupt flag.

The local address is the paragraph register times 16 plus the sub-paragraph nibble. On a 16-bit channel the address is folded: the top two address bits are kept and the paragraph part is doubled. In that mode each unit is two bytes. Bytes written into local memory can have their sign bit flipped, so that unsigned sample data can be converted. The first byte of each unit can be exempted from this flip. In the other direction, bytes are read from local memory and passed to the outgoing stream unchanged.

The control register is read-to-clear. A read reports the terminal-count flag and the channel width, and then drops the flag together with two stored bits.

Top module: `wavemem_dma`

## Requirements
- R1: With control bit 1 = 0, each byte accepted on the input stream (valid and ready both high) is written to local memory. The bytes go to consecutive addresses starting at the base, and the address wraps at 2^20. On an 8-bit channel (`wideChan` = 0) the base is paragraph*16 + nibble.
- R2: On a 16-bit channel (`wideChan` = 1) the base is (off AND 0xC0000) + 2*(off AND 0x1FFF0), where off = paragraph*16 + nibble. Each unit moves two bytes.
- R3: After a block of N units, the paragraph register becomes paragraph + (N >> 4) mod 2^16. The nibble becomes (nibble + N) mod 16, and the carry is discarded.
- R4: With control bit 1 = 1, bytes are read from local memory in address order and offered on the output stream. No local write takes place and the input stream is never ready. With bit 1 = 0, nothing is offered on the output stream.
- R5: With control bit 7 set and bit 1 = 0, bit 7 of each written byte is inverted. With bit 1 = 1, output bytes are never altered.
- R6: With control bit 6 set, the first byte of each unit is written without inversion. On an 8-bit channel this applies to every byte, and on a 16-bit channel to the even bytes.
- R7: At terminal count, control bit 0 reads back as 0. If control bit 5 is set, the pending flag is set and `irqPending` goes high.
- R8: A control read (`regSel` = 0) returns the stored byte, with bit 6 ORed with the pending flag and bit 2 ORed with `wideChan`. It then clears the pending flag and stored bits 6 and 2.
- R9: Writing the control register with bit 0 = 1 while idle starts a block of `blockUnits` units. A count of zero moves no byte and goes straight to terminal count.
- R10: While a block is in progress, writes to the control (sel 0), paragraph (sel 1) and nibble (sel 2, bits 3:0) registers are ignored.
- R11: After reset all registers read 0, `irqPending` is low, and no stream or memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects apply at the clock edge) |
| regSel | input | 2 | 0 control, 1 paragraph start, 2 sub-paragraph nibble |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regSel` |
| wideChan | input | 1 | Channel is 16-bit |
| blockUnits | input | 12 | Units in the next block, sampled at start |
| sysInValid | input | 1 | Input stream byte valid |
| sysInReady | output | 1 | Input stream ready |
| sysInData | input | 8 | Input stream byte |
| sysOutValid | output | 1 | Output stream byte valid |
| sysOutReady | input | 1 | Output stream ready |
| sysOutData | output | 8 | Output stream byte |
| memEn | output | 1 | Local memory enable |
| memWe | output | 1 | Local memory write enable |
| memAddr | output | 20 | Local memory byte address |
| memWrData | output | 8 | Local memory write byte |
| memRdData | input | 8 | Local memory read byte, one cycle after the request |
| irqPending | output | 1 | Terminal-count interrupt pending |

## Verification
The main function is driven by a sweep over both channel widths, both directions and all eight combinations of the invert, low-byte-pass and interrupt-enable bits. Unit counts below, equal to and above 16 separate the paragraph advance from the nibble carry loss. Paragraph values near the top of the range force wrap of both the address and the advance. Input and output handshakes are throttled on half the runs, which separates per-handshake stepping from per-cycle stepping. A zero-unit block, a block disturbed by register writes, and a control write that sets only bits 6 and 2 separate the start, lock-out and read-to-clear rules.

// File: rtl/wavemem_dma_pkg.sv
package wavemem_dma_pkg;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_PARA = 2'd1;
  localparam logic [1:0] SEL_NIB  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MOVE,
    ST_RDREQ,
    ST_RDWAIT,
    ST_RDHOLD,
    ST_DONE
  } dmaState_t;

  typedef struct packed {
    logic loadAddr;
    logic stepAddr;
    logic memWrite;
    logic memRead;
    logic captureRd;
    logic commit;
  } dpStrobe_t;

endpackage

// File: rtl/wavemem_dma_ctrl.sv
module wavemem_dma_ctrl
  import wavemem_dma_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regSel,
  input  logic [7:0]       regWrByte,
  input  logic             wideChan,
  input  logic [CNT_W-1:0] blockUnits,
  input  logic             sysInValid,
  input  logic             sysOutReady,
  output logic             sysInReady,
  output logic             sysOutValid,
  output logic [7:0]       ctrlRdData,
  output logic             irqPending,
  output logic             busy,
  output logic             wideLat,
  output logic [CNT_W-1:0] unitsLat,
  output logic             invEn,
  output logic             lowPass,
  output dpStrobe_t        strobe
);

  dmaState_t        state;
  dmaState_t        stateNext;
  logic [7:0]       ctrlReg;
  logic [7:0]       ctrlNext;
  logic             tcPending;
  logic [CNT_W:0]   bytesLeft;
  logic             ctrlWr;
  logic             ctrlRd;
  logic             startReq;
  logic             lastByte;
  logic             byteDone;

  assign busy     = (state != ST_IDLE);
  assign ctrlWr   = regWrEn && (regSel == SEL_CTRL) && !busy;
  assign ctrlRd   = regRdEn && (regSel == SEL_CTRL);
  assign startReq = ctrlWr && regWrByte[0];
  assign lastByte = (bytesLeft == {{CNT_W{1'b0}}, 1'b1});

  assign invEn   = ctrlReg[7] && !ctrlReg[1];
  assign lowPass = ctrlReg[6];

  assign sysInReady  = (state == ST_MOVE);
  assign sysOutValid = (state == ST_RDHOLD);
  assign irqPending  = tcPending;

  assign ctrlRdData = {ctrlReg[7], ctrlReg[6] | tcPending, ctrlReg[5:3],
                       ctrlReg[2] | wideChan, ctrlReg[1:0]};

  always_comb begin
    byteDone = 1'b0;
    strobe   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.loadAddr = 1'b1;
          if (blockUnits == '0)      stateNext = ST_DONE;
          else if (regWrByte[1])     stateNext = ST_RDREQ;
          else                       stateNext = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (sysInValid) begin
          strobe.memWrite = 1'b1;
          strobe.stepAddr = 1'b1;
          byteDone = 1'b1;
          if (lastByte) stateNext = ST_DONE;
        end
      end
      ST_RDREQ: begin
        strobe.memRead  = 1'b1;
        strobe.stepAddr = 1'b1;
        stateNext = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        strobe.captureRd = 1'b1;
        stateNext = ST_RDHOLD;
      end
      ST_RDHOLD: begin
        if (sysOutReady) begin
          byteDone = 1'b1;
          stateNext = lastByte ? ST_DONE : ST_RDREQ;
        end
      end
      ST_DONE: begin
        strobe.commit = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrlNext = ctrlReg;
    if (ctrlRd) ctrlNext = ctrlNext & 8'hBB;
    if (state == ST_DONE) ctrlNext[0] = 1'b0;
    if (ctrlWr) ctrlNext = regWrByte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ctrlReg   <= '0;
      tcPending <= 1'b0;
      bytesLeft <= '0;
      wideLat   <= 1'b0;
      unitsLat  <= '0;
    end else begin
      state   <= stateNext;
      ctrlReg <= ctrlNext;
      if (state == ST_DONE && ctrlReg[5]) tcPending <= 1'b1;
      else if (ctrlRd)                    tcPending <= 1'b0;
      if (startReq) begin
        wideLat   <= wideChan;
        unitsLat  <= blockUnits;
        bytesLeft <= wideChan ? {blockUnits, 1'b0} : {1'b0, blockUnits};
      end else if (byteDone) begin
        bytesLeft <= bytesLeft - 1'b1;
      end
    end
  end

  // R7: request bit drops once terminal count is handled
  a_r7_tc_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> !ctrlReg[0]);

  // R8: a control read leaves no pending flag unless a new terminal count lands
  a_r8_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlRd && state != ST_DONE) |=> !tcPending);

  // R1: a local write only ever comes from an offered input byte
  a_r1_write_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.memWrite |-> (sysInValid && sysInReady));

  // R4: the two stream sides are never active together
  a_r4_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sysInReady, sysOutValid}));

  // R10: direction, inversion and irq enable hold for a whole block
  a_r10_config_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({ctrlReg[7], ctrlReg[5], ctrlReg[1]}));

endmodule

// File: rtl/wavemem_dma_path.sv
module wavemem_dma_path
  import wavemem_dma_pkg::*;
#(
  parameter  int PARA_W = 16,
  parameter  int CNT_W  = 12,
  localparam int ADDR_W = PARA_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [PARA_W-1:0] regWrData,
  input  logic              busy,
  input  logic              wideChan,
  input  logic              wideLat,
  input  logic [CNT_W-1:0]  unitsLat,
  input  logic              invEn,
  input  logic              lowPass,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        sysInData,
  input  logic [7:0]        memRdData,
  output logic [7:0]        sysOutData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic [PARA_W-1:0] paraRdData,
  output logic [3:0]        nibRdData
);

  logic [PARA_W-1:0] startReg;
  logic [3:0]        nibReg;
  logic [ADDR_W-1:0] rawOff;
  logic [ADDR_W-1:0] foldOff;
  logic [ADDR_W-1:0] baseOff;
  logic [ADDR_W-1:0] addrCnt;
  logic              phase;
  logic              firstOfUnit;
  logic              flipBit;
  logic [7:0]        holdReg;
  logic              wrPara;
  logic              wrNib;

  assign wrPara = regWrEn && (regSel == SEL_PARA) && !busy;
  assign wrNib  = regWrEn && (regSel == SEL_NIB)  && !busy;

  assign rawOff  = {startReg, 4'b0000} + {{PARA_W{1'b0}}, nibReg};
  assign foldOff = {rawOff[ADDR_W-1:ADDR_W-2], {(ADDR_W-2){1'b0}}}
                 | {2'b00, rawOff[ADDR_W-4:4], 5'b00000};
  assign baseOff = wideChan ? foldOff : rawOff;

  assign firstOfUnit = !wideLat || !phase;
  assign flipBit     = invEn && !(lowPass && firstOfUnit);

  assign memEn      = strobe.memWrite || strobe.memRead;
  assign memWe      = strobe.memWrite;
  assign memAddr    = addrCnt;
  assign memWrData  = {sysInData[7] ^ flipBit, sysInData[6:0]};
  assign sysOutData = holdReg;
  assign paraRdData = startReg;
  assign nibRdData  = nibReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startReg <= '0;
      nibReg   <= '0;
      addrCnt  <= '0;
      phase    <= 1'b0;
      holdReg  <= '0;
    end else begin
      if (wrPara) startReg <= regWrData;
      if (wrNib)  nibReg   <= regWrData[3:0];
      if (strobe.commit) begin
        startReg <= startReg + PARA_W'(unitsLat >> 4);
        nibReg   <= nibReg + unitsLat[3:0];
      end
      if (strobe.loadAddr) begin
        addrCnt <= baseOff;
        phase   <= 1'b0;
      end else if (strobe.stepAddr) begin
        addrCnt <= addrCnt + 1'b1;
        phase   <= wideLat ? !phase : 1'b0;
      end
      if (strobe.captureRd) holdReg <= memRdData;
    end
  end

  // R2: a folded 16-bit base always starts on an even byte
  a_r2_fold_even: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadAddr && wideChan) |=> !addrCnt[0]);

  // R3: the start registers only move at commit or by an idle write
  a_r3_para_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !strobe.commit) |=> $stable(startReg));

endmodule

// File: rtl/wavemem_dma.sv
module wavemem_dma
  import wavemem_dma_pkg::*;
#(
  parameter  int PARA_W = 16,
  parameter  int CNT_W  = 12,
  localparam int ADDR_W = PARA_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regSel,
  input  logic [PARA_W-1:0] regWrData,
  output logic [PARA_W-1:0] regRdData,
  input  logic              wideChan,
  input  logic [CNT_W-1:0]  blockUnits,
  input  logic              sysInValid,
  output logic              sysInReady,
  input  logic [7:0]        sysInData,
  output logic              sysOutValid,
  input  logic              sysOutReady,
  output logic [7:0]        sysOutData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData,
  output logic              irqPending
);

  dpStrobe_t         strobe;
  logic              busy;
  logic              wideLat;
  logic [CNT_W-1:0]  unitsLat;
  logic              invEn;
  logic              lowPass;
  logic [7:0]        ctrlRdData;
  logic [PARA_W-1:0] paraRdData;
  logic [3:0]        nibRdData;

  wavemem_dma_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regSel     (regSel),
    .regWrByte  (regWrData[7:0]),
    .wideChan   (wideChan),
    .blockUnits (blockUnits),
    .sysInValid (sysInValid),
    .sysOutReady(sysOutReady),
    .sysInReady (sysInReady),
    .sysOutValid(sysOutValid),
    .ctrlRdData (ctrlRdData),
    .irqPending (irqPending),
    .busy       (busy),
    .wideLat    (wideLat),
    .unitsLat   (unitsLat),
    .invEn      (invEn),
    .lowPass    (lowPass),
    .strobe     (strobe)
  );

  wavemem_dma_path #(.PARA_W(PARA_W), .CNT_W(CNT_W)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .regWrData  (regWrData),
    .busy       (busy),
    .wideChan   (wideChan),
    .wideLat    (wideLat),
    .unitsLat   (unitsLat),
    .invEn      (invEn),
    .lowPass    (lowPass),
    .strobe     (strobe),
    .sysInData  (sysInData),
    .memRdData  (memRdData),
    .sysOutData (sysOutData),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .paraRdData (paraRdData),
    .nibRdData  (nibRdData)
  );

  always_comb begin
    unique case (regSel)
      SEL_CTRL: regRdData = {{(PARA_W-8){1'b0}}, ctrlRdData};
      SEL_PARA: regRdData = paraRdData;
      SEL_NIB:  regRdData = {{(PARA_W-4){1'b0}}, nibRdData};
      default:  regRdData = '0;
    endcase
  end

endmodule

// File: tb/wavemem_dma_test.sv
module wavemem_dma_test;

  localparam int PARA_W = 16;
  localparam int CNT_W  = 12;
  localparam int ADDR_W = PARA_W + 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              regWrEn = 1'b0;
  logic              regRdEn = 1'b0;
  logic [1:0]        regSel = 2'd0;
  logic [PARA_W-1:0] regWrData = '0;
  logic [PARA_W-1:0] regRdData;
  logic              wideChan = 1'b0;
  logic [CNT_W-1:0]  blockUnits = '0;
  logic              sysInValid;
  logic              sysInReady;
  logic [7:0]        sysInData;
  logic              sysOutValid;
  logic              sysOutReady;
  logic [7:0]        sysOutData;
  logic              memEn;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memWrData;
  logic [7:0]        memRdData = '0;
  logic              irqPending;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] memArr [int unsigned];
  int   inIdx = 0;
  int   inBase = 0;
  logic [3:0] vTick = '0;
  logic throttle = 1'b0;
  logic inEnable = 1'b0;
  logic outEnable = 1'b0;
  int   wrCnt = 0;
  int   outCnt = 0;
  logic [ADDR_W-1:0] wrAddr [0:255];
  logic [7:0]        wrData [0:255];
  logic [7:0]        outData [0:255];

  always #10 clk = ~clk;

  wavemem_dma uut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .wideChan(wideChan), .blockUnits(blockUnits),
    .sysInValid(sysInValid), .sysInReady(sysInReady), .sysInData(sysInData),
    .sysOutValid(sysOutValid), .sysOutReady(sysOutReady), .sysOutData(sysOutData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .irqPending(irqPending)
  );

  function automatic logic [7:0] genByte(input int i);
    return 8'(i * 37 + 11) ^ 8'(i >> 3);
  endfunction

  function automatic logic [7:0] memVal(input logic [ADDR_W-1:0] a);
    if (memArr.exists(int'(a))) return memArr[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [ADDR_W-1:0] calcBase(input logic w, input logic [15:0] s,
                                                 input logic [3:0] e);
    int unsigned off;
    off = (int'(s) * 16 + int'(e)) % (1 << 20);
    if (w) off = ((off & 32'hC0000) + 2 * (off & 32'h1FFF0)) % (1 << 20);
    return ADDR_W'(off);
  endfunction

  assign sysInData   = genByte(inIdx);
  assign sysInValid  = inEnable && (!throttle || vTick[1:0] != 2'd1);
  assign sysOutReady = outEnable && (!throttle || vTick[0]);

  always @(posedge clk) begin
    vTick <= vTick + 1'b1;
    if (sysInValid && sysInReady) inIdx <= inIdx + 1;
    if (memEn && !memWe) memRdData <= memVal(memAddr);
  end

  always @(negedge clk) begin
    if (memEn && memWe) begin
      if (wrCnt < 256) begin
        wrAddr[wrCnt] = memAddr;
        wrData[wrCnt] = memWrData;
      end
      memArr[int'(memAddr)] = memWrData;
      wrCnt = wrCnt + 1;
    end
    if (sysOutValid && sysOutReady) begin
      if (outCnt < 256) outData[outCnt] = sysOutData;
      outCnt = outCnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [15:0] d);
    @(posedge clk); #2;
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(posedge clk); #2;
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [15:0] v);
    @(posedge clk); #2;
    regRdEn = 1'b1; regSel = sel;
    @(negedge clk);
    v = regRdData;
    @(posedge clk); #2;
    regRdEn = 1'b0;
  endtask

  task automatic waitBytes(input logic dir, input int want);
    int t;
    t = 0;
    while (((dir ? outCnt : wrCnt) < want) && t < 3000) begin
      @(posedge clk);
      t++;
    end
    check(t < 3000, "R9 block completes", dir ? outCnt : wrCnt, want);
    repeat (6) @(posedge clk);
    #2;
  endtask

  // one complete block, checked against the requirements
  task automatic runBlock(input logic w, input logic dir, input logic inv, input logic b6,
                          input logic b5, input logic [15:0] s, input logic [3:0] e,
                          input int n, input logic thr, input logic disturb);
    logic [15:0] v;
    logic [7:0]  cv;
    logic [ADDR_W-1:0] base;
    int nb;
    bit dataOk;
    bit addrOk;
    int badA;
    int badE;
    wideChan = w;
    throttle = thr;
    regWrite(2'd1, s);
    regWrite(2'd2, {12'h0, e});
    blockUnits = CNT_W'(n);
    base = calcBase(w, s, e);
    nb = n * (w ? 2 : 1);
    wrCnt = 0;
    outCnt = 0;
    inBase = inIdx;
    inEnable = !dir;
    outEnable = dir;
    cv = {inv, b6, b5, 3'b000, dir, 1'b1};
    regWrite(2'd0, {8'h00, cv});
    if (disturb) begin
      regWrite(2'd1, 16'h1234);
      regWrite(2'd2, 16'h0009);
      regWrite(2'd0, 16'h0000);
    end
    if (n > 0) waitBytes(dir, nb);
    else begin
      repeat (6) @(posedge clk);
      #2;
    end
    inEnable = 1'b0;
    outEnable = 1'b0;
    // R4: only the selected side moves
    check((dir ? wrCnt : outCnt) == 0, "R4 other side idle", dir ? wrCnt : outCnt, 0);
    check((dir ? outCnt : wrCnt) == nb, "R1/R4 byte count", dir ? outCnt : wrCnt, nb);
    dataOk = 1;
    addrOk = 1;
    badA = 0;
    badE = 0;
    for (int j = 0; j < nb && j < 256; j++) begin
      logic [ADDR_W-1:0] ea;
      logic [7:0] ed;
      bit flip;
      ea = base + ADDR_W'(j);
      if (!dir) begin
        flip = inv && !(b6 && (!w || (j % 2 == 0)));
        ed = genByte(inBase + j) ^ (flip ? 8'h80 : 8'h00);
        if (wrAddr[j] != ea && addrOk) begin addrOk = 0; badA = int'(wrAddr[j]); badE = int'(ea); end
        if (wrData[j] != ed && dataOk) begin
          dataOk = 0;
          $display("FAIL R5/R6 write byte %0d actual %0h expected %0h", j, wrData[j], ed);
        end
      end else begin
        ed = memVal(ea);
        if (outData[j] != ed && dataOk) begin
          dataOk = 0;
          $display("FAIL R4/R5 read byte %0d actual %0h expected %0h", j, outData[j], ed);
        end
      end
    end
    check(addrOk, w ? "R2 folded address" : "R1 linear address", badA, badE);
    checks++;
    if (!dataOk) errors++;
    // R7: terminal-count interrupt follows bit 5
    check(irqPending == b5, "R7 irq pending", int'(irqPending), int'(b5));
    // R3: start registers advance
    regRead(2'd1, v);
    check(v == 16'(s + 16'(n >> 4)), "R3 paragraph advance", v, 16'(s + 16'(n >> 4)));
    regRead(2'd2, v);
    check(v == {12'h0, 4'(int'(e) + n)}, "R3 nibble advance", v, {12'h0, 4'(int'(e) + n)});
    // R8/R7: read with flag, then read again after clear
    regRead(2'd0, v);
    begin
      logic [7:0] exp1;
      logic [7:0] exp2;
      exp1 = {inv, b6 | b5, b5, 2'b00, w, dir, 1'b0};
      exp2 = {inv, 1'b0, b5, 2'b00, w, dir, 1'b0};
      check(v[7:0] == exp1, "R7/R8 control first read", v, exp1);
      regRead(2'd0, v);
      check(v[7:0] == exp2, "R8 control second read", v, exp2);
    end
    check(irqPending == 1'b0, "R8 flag cleared by read", int'(irqPending), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int k;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    // R11: reset state
    check(!irqPending && !sysInReady && !sysOutValid && !memEn, "R11 idle strobes",
          {irqPending, sysInReady, sysOutValid, memEn}, 0);
    regRead(2'd0, v);
    check(v == 16'h0000, "R11 control reset", v, 0);
    regRead(2'd1, v);
    check(v == 16'h0000, "R11 paragraph reset", v, 0);
    regRead(2'd2, v);
    check(v == 16'h0000, "R11 nibble reset", v, 0);

    // R8: stored bits 6 and 2 clear on read, no start without bit 0
    regWrite(2'd0, 16'h0044);
    check(!memEn && !sysInReady, "R9 no start without bit 0", {memEn, sysInReady}, 0);
    regRead(2'd0, v);
    check(v == 16'h0044, "R8 stored bits first read", v, 16'h0044);
    regRead(2'd0, v);
    check(v == 16'h0000, "R8 stored bits cleared", v, 0);
    wideChan = 1'b1;
    regRead(2'd0, v);
    check(v == 16'h0004, "R8 wide channel bit", v, 16'h0004);
    wideChan = 1'b0;

    // main sweep: width x direction x control bits x counts
    k = 0;
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 8; c++)
          for (int ni = 0; ni < 4; ni++) begin
            int n;
            n = (ni == 0) ? 1 : (ni == 1) ? 7 : (ni == 2) ? 16 : 33;
            runBlock(w[0], d[0], c[2], c[1], c[0], 16'(16'hFFF3 + k * 16'h0913),
                     4'(k * 5), n, k[0], 1'b0);
            k++;
          end

    // R9: zero-unit block finishes at once
    runBlock(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0420, 4'h3, 0, 1'b0, 1'b0);
    // R10: register writes during a block are ignored
    runBlock(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h2000, 4'hA, 40, 1'b1, 1'b1);
    runBlock(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h3FFF, 4'h7, 20, 1'b1, 1'b1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule